// File: doc/BRIEF.md
# Carry-Pipelined Segmented Accumulator

This block keeps a wide running sum. On each clock with the add enable high, the input word is added into the sum. The sum is split into equal lanes. A single flop at each lane boundary holds the carry out of the lower lane and feeds it into the upper lane one clock later. The longest combinational path is therefore one lane's carry chain, not the whole width. Normal adds run at one per clock and may leave carries parked in those boundary flops.

Before the sum is read, software-side logic raises a readout request. While the add enable is low, the block then performs additions of zero until no boundary carry remains. A valid flag shows that the output equals the true sum. If no carry is parked, the flag is already high and no cycles are spent. The sum wraps modulo two to the power of the total width.

Top module: `seg_accum`

## Requirements
- R1: Once every boundary carry has been flushed, `acc_out` equals the sum of all `din` values taken with `add_en` high since the last reset, modulo 2^TOTAL_W. The carry out of the most significant lane is discarded.
- R2: Lane i (bits i*SEG_W upward, lane 0 least significant) adds its slice of `din` together with the carry that lane i-1 produced on the previous advancing clock. That carry is not applied in the clock that generates it.
- R3: `acc_valid` is low while any boundary carry flop holds a 1, and high while none does.
- R4: While `add_en` is low and no flush is in progress, `acc_out` and `acc_valid` hold their values.
- R5: A readout request with `add_en` low makes the block advance with zero input on every clock until `acc_valid` rises. This takes at most TOTAL_W/SEG_W-1 clocks.
- R6: A readout request while `acc_valid` is high and `add_en` is low leaves `acc_out` unchanged, and `acc_valid` stays high.
- R7: Synchronous reset, active high, sets `acc_out` to zero and `acc_valid` high on the following clock.
- R8: With `add_en` high, one word is added on every clock whether or not carries are pending, and also during a flush.
- R9: A one-clock pulse on `rd_req` is enough. The flush keeps going until `acc_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| add_en | input | 1 | Add `din` on this clock |
| din | input | TOTAL_W | Word to accumulate |
| rd_req | input | 1 | Start a carry flush for readout |
| acc_out | output | TOTAL_W | Accumulated value (lanes concatenated) |
| acc_valid | output | 1 | High when no boundary carry is pending |

## Verification
A carry lost or doubled in a boundary flop shows up as a wrong lane in `acc_out` on the clock after the next advancing edge. That lane is off by exactly 2^(i*SEG_W). A stuck or forgotten flush state shows up as `acc_valid` staying low past the TOTAL_W/SEG_W-1 clock bound, or as `acc_out` moving while the block should be idle. A behavioural model follows the lanes and the flush state on every clock, so either kind of error is caught at the clock on which it first appears.

// File: rtl/seg_accum_pkg.sv
package seg_accum_pkg;

  // number of lanes for a given total and lane width
  function automatic int unsigned lane_count(input int unsigned total_w,
                                             input int unsigned seg_w);
    return total_w / seg_w;
  endfunction

  // number of boundary carry flops between lanes
  function automatic int unsigned cut_count(input int unsigned total_w,
                                            input int unsigned seg_w);
    return (total_w / seg_w) - 1;
  endfunction

  // worst-case zero-input clocks needed to drain all carries
  function automatic int unsigned flush_bound(input int unsigned total_w,
                                              input int unsigned seg_w);
    return cut_count(total_w, seg_w);
  endfunction

endpackage

// File: rtl/seg_accum_lane.sv
module seg_accum_lane #(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEG_W-1:0] add_word,
  input  logic             cin,
  output logic [SEG_W-1:0] seg_q,
  output logic             cout_q
);

  // lane adder with carry out
  function automatic logic [SEG_W:0] lane_add(input logic [SEG_W-1:0] a,
                                              input logic [SEG_W-1:0] b,
                                              input logic             ci);
    return {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, ci};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      cout_q <= 1'b0;
    end else if (step) begin
      {cout_q, seg_q} <= lane_add(seg_q, add_word, cin);
    end
  end

endmodule

// File: rtl/seg_accum_head.sv
module seg_accum_head #(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SEG_W-1:0] add_word,
  input  logic             cin,
  output logic [SEG_W-1:0] seg_q
);

  // most significant lane: the carry out falls off the top
  function automatic logic [SEG_W-1:0] wrap_add(input logic [SEG_W-1:0] a,
                                                input logic [SEG_W-1:0] b,
                                                input logic             ci);
    return a + b + {{(SEG_W-1){1'b0}}, ci};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
    end else if (step) begin
      seg_q <= wrap_add(seg_q, add_word, cin);
    end
  end

endmodule

// File: rtl/seg_accum_flush.sv
module seg_accum_flush #(
  parameter int unsigned NCUT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            add_en,
  input  logic            rd_req,
  input  logic [NCUT-1:0] carry_q,
  output logic            step,
  output logic            flush_go,
  output logic            acc_valid
);

  logic flush_q;

  // valid comes straight from registered carry state
  assign acc_valid = ~|carry_q;
  assign flush_go  = (rd_req | flush_q) & ~acc_valid;
  assign step      = add_en | flush_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_go;
    end
  end

endmodule

// File: rtl/seg_accum.sv
module seg_accum
  import seg_accum_pkg::*;
#(
  parameter int unsigned TOTAL_W = 32,
  parameter int unsigned SEG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add_en,
  input  logic [TOTAL_W-1:0] din,
  input  logic               rd_req,
  output logic [TOTAL_W-1:0] acc_out,
  output logic               acc_valid
);

  localparam int unsigned NSEG = lane_count(TOTAL_W, SEG_W);
  localparam int unsigned NCUT = cut_count(TOTAL_W, SEG_W);

  logic               step;
  logic               flush_go;
  logic [NCUT-1:0]    carry_q;
  logic [TOTAL_W-1:0] add_word;

  // zero input while flushing without an add
  assign add_word = add_en ? din : '0;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic cin_g;
    if (g == 0) begin : g_first
      assign cin_g = 1'b0;
    end else begin : g_rest
      assign cin_g = carry_q[g-1];
    end
    if (g < NSEG - 1) begin : g_lane
      seg_accum_lane #(.SEG_W(SEG_W)) lane_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .add_word (add_word[g*SEG_W +: SEG_W]),
        .cin      (cin_g),
        .seg_q    (acc_out[g*SEG_W +: SEG_W]),
        .cout_q   (carry_q[g])
      );
    end else begin : g_head
      seg_accum_head #(.SEG_W(SEG_W)) head_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .add_word (add_word[g*SEG_W +: SEG_W]),
        .cin      (cin_g),
        .seg_q    (acc_out[g*SEG_W +: SEG_W])
      );
    end
  end

  seg_accum_flush #(.NCUT(NCUT)) flush_i (
    .clk       (clk),
    .rst       (rst),
    .add_en    (add_en),
    .rd_req    (rd_req),
    .carry_q   (carry_q),
    .step      (step),
    .flush_go  (flush_go),
    .acc_valid (acc_valid)
  );

endmodule

// File: rtl/seg_accum_chk.sv
module seg_accum_chk
  import seg_accum_pkg::*;
#(
  parameter int unsigned TOTAL_W = 32,
  parameter int unsigned SEG_W   = 8
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  add_en,
  input logic                                  rd_req,
  input logic [TOTAL_W-1:0]                    acc_out,
  input logic                                  acc_valid,
  input logic [cut_count(TOTAL_W, SEG_W)-1:0]  carry_q,
  input logic                                  flush_go
);

  localparam int unsigned NCUT = cut_count(TOTAL_W, SEG_W);
  localparam int unsigned CW   = $clog2(NCUT + 2);

  logic [CW-1:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst || !(flush_go && !add_en)) zero_run <= '0;
    else                               zero_run <= zero_run + 1'b1;
  end

  assert_invalid_when_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (|carry_q) |-> !acc_valid);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!add_en && !flush_go) |=> ($stable(acc_out) && $stable(carry_q)));

  assert_zero_step_clears_low_cut_R2: assert property (@(posedge clk) disable iff (rst)
    (flush_go && !add_en) |=> !carry_q[0]);

  assert_flush_bound_R5: assert property (@(posedge clk) disable iff (rst)
    zero_run <= CW'(flush_bound(TOTAL_W, SEG_W)));

  assert_valid_read_no_change_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && acc_valid && !add_en) |=> ($stable(acc_out) && acc_valid));

  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && acc_valid));

endmodule

bind seg_accum seg_accum_chk #(.TOTAL_W(TOTAL_W), .SEG_W(SEG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .add_en    (add_en),
  .rd_req    (rd_req),
  .acc_out   (acc_out),
  .acc_valid (acc_valid),
  .carry_q   (carry_q),
  .flush_go  (flush_go)
);

// File: tb/seg_accum_tb_top.sv
`timescale 1ns/1ps
module seg_accum_tb_top;

  localparam int TOTAL_W = 32;
  localparam int SEG_W   = 8;
  localparam int NSEG    = TOTAL_W / SEG_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               add_en = 1'b0;
  logic [TOTAL_W-1:0] din = '0;
  logic               rd_req = 1'b0;
  logic [TOTAL_W-1:0] acc_out;
  logic               acc_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int               m_lane [NSEG];
  bit               m_car  [NSEG];
  bit               m_flush;
  logic [TOTAL_W-1:0] m_sum;

  always #4 clk = ~clk;

  seg_accum #(.TOTAL_W(TOTAL_W), .SEG_W(SEG_W)) dut_i (
    .clk(clk), .rst(rst), .add_en(add_en), .din(din),
    .rd_req(rd_req), .acc_out(acc_out), .acc_valid(acc_valid)
  );

  function automatic logic [TOTAL_W-1:0] m_out();
    logic [TOTAL_W-1:0] v;
    for (int i = 0; i < NSEG; i++) v[i*SEG_W +: SEG_W] = m_lane[i][SEG_W-1:0];
    return v;
  endfunction

  function automatic bit m_valid();
    for (int i = 0; i < NSEG - 1; i++) if (m_car[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [TOTAL_W-1:0] act,
                     input logic [TOTAL_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance model, sample after the edge, compare
  task automatic cyc(input bit r, input bit en, input logic [TOTAL_W-1:0] d,
                     input bit rd);
    int nl [NSEG];
    bit nc [NSEG];
    bit go;
    @(negedge clk);
    rst = r; add_en = en; din = d; rd_req = rd;
    if (r) begin
      for (int i = 0; i < NSEG; i++) begin m_lane[i] = 0; m_car[i] = 0; end
      m_flush = 0; m_sum = '0;
    end else begin
      go = (rd || m_flush) && !m_valid();
      if (en || go) begin
        for (int i = 0; i < NSEG; i++) begin
          int a;
          a = m_lane[i] + (en ? int'(d[i*SEG_W +: SEG_W]) : 0)
              + ((i > 0 && m_car[i-1]) ? 1 : 0);
          nl[i] = a % (1 << SEG_W);
          nc[i] = (i < NSEG - 1) ? (a >= (1 << SEG_W)) : 1'b0;
        end
        for (int i = 0; i < NSEG; i++) begin m_lane[i] = nl[i]; m_car[i] = nc[i]; end
      end
      if (en) m_sum = m_sum + d;
      m_flush = go;
    end
    @(posedge clk); #1;
    chk("R2 lane contents", acc_out, m_out());
    chk("R3 valid flag", {31'b0, acc_valid}, {31'b0, m_valid()});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, '0, 0);
    cyc(0, 0, '0, 0);
    // R7 reset state
    chk("R7 reset value", acc_out, 32'h0);
    chk("R7 reset valid", {31'b0, acc_valid}, 32'h1);

    // R2/R3 carry parked at cut 0
    cyc(0, 1, 32'h0000_00FF, 0);
    cyc(0, 1, 32'h0000_0001, 0);
    chk("R2 carry delayed", acc_out, 32'h0000_0000);
    chk("R3 pending gives invalid", {31'b0, acc_valid}, 32'h0);
    // R4 idle holds
    cyc(0, 0, 32'h1234_5678, 0);
    chk("R4 idle hold", acc_out, 32'h0000_0000);
    // R5 single flush clock
    cyc(0, 0, '0, 1);
    chk("R5 flushed value", acc_out, 32'h0000_0100);
    chk("R5 valid after flush", {31'b0, acc_valid}, 32'h1);
    // R6 readout when already valid
    cyc(0, 0, '0, 1);
    chk("R6 no change on valid read", acc_out, 32'h0000_0100);

    // R5/R9/R1 worst-case ripple with wrap
    cyc(1, 0, '0, 0);
    cyc(0, 1, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 32'h0000_0001, 0);
    chk("R2 ripple start", acc_out, 32'hFFFF_FF00);
    cyc(0, 0, '0, 1);
    chk("R9 flush step 1", acc_out, 32'hFFFF_0000);
    cyc(0, 0, '0, 0);
    chk("R9 flush step 2", acc_out, 32'hFF00_0000);
    chk("R5 still invalid", {31'b0, acc_valid}, 32'h0);
    cyc(0, 0, '0, 0);
    chk("R1 wrap to zero", acc_out, 32'h0000_0000);
    chk("R5 valid within bound", {31'b0, acc_valid}, 32'h1);
    cyc(0, 0, '0, 0);
    chk("R4 hold after flush", acc_out, 32'h0000_0000);

    // R8 back-to-back adds with carries pending, then flush and compare sum
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 50; j++)
        cyc(0, 1, $urandom, (j % 7) == 3);
      cyc(0, 0, '0, 1);
      for (int j = 0; j < NSEG; j++) cyc(0, 0, '0, 0);
      chk("R1 sum after flush", acc_out, m_sum);
      chk("R8 valid after adds", {31'b0, acc_valid}, 32'h1);
    end

    // R7 reset with carries pending
    cyc(0, 1, 32'h00FF_FFFF, 0);
    cyc(0, 1, 32'h0000_0001, 0);
    cyc(1, 1, 32'h0000_0001, 0);
    chk("R7 reset clears pending", acc_out, 32'h0);
    chk("R7 reset valid high", {31'b0, acc_valid}, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule